// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider Bank

This block takes one fast clock and derives thirteen slower clocks from it. There are three banks of four lanes each (A, B and C) and one feedback lane. Each bank has a two-bit code that picks its divide ratio. The feedback lane has a three-bit code. A single fast-mode input selects the base ratios when high. When it is low, every ratio is doubled. All ratios are even, so every lane runs at a 50% duty cycle.

Codes can be changed while the clock is running. The control logic first passes every control input through a two-flop synchronizer. A counter then takes up a new ratio only at the rising edge that starts its next period. Because of this, no period is ever shorter or longer than both the old ratio and the new one. A flip control inverts lanes 2 and 3 of bank C. A per-lane enable holds a lane low and releases it only at the start of a full period. The active-low reset clears every flop and forces all outputs low. After it is released, all lanes start together on one edge.

Top module: `clkdiv_bank`

## Requirements
- R1: With fastMode high, bank A divides by 4, 6, 8 or 12 for codeA values 0, 1, 2 and 3.
- R2: With fastMode high, bank B divides by 4, 6, 8 or 10, and bank C divides by 2, 4, 6 or 8, for code values 0, 1, 2 and 3.
- R3: With fastMode low, every bank and feedback ratio is twice its fastMode-high value.
- R4: The feedback lane divides by 4, 6, 8 or 10 for fbCode[1:0] values 0 to 3, and fbCode[2]=1 doubles that ratio.
- R5: Every enabled lane is high for ratio/2 fast cycles and then low for ratio/2 fast cycles.
- R6: After any code or fastMode change, each complete output period equals either the old ratio or the new one. A period that uses the new ratio is never followed by one that uses the old ratio.
- R7: When flipC23 is high, lanes clkC[2] and clkC[3] are the complement of clkC[0], and lane clkC[1] is unchanged. When flipC23 is low, all four bank C lanes match.
- R8: While resetN is low, all thirteen outputs are low, and they go low as soon as resetN falls.
- R9: After resetN rises, every enabled lane rises for the first time on the same fast-clock edge, which is the third rising edge after the release.
- R10: A lane whose laneEn bit (bit 4*bank+lane, bank A=0) is low stays low. After it is re-enabled, its first rise coincides with the rise that starts a period of its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| resetN | input | 1 | Active-low master reset and output enable |
| fastMode | input | 1 | High: base ratios; low: all ratios doubled |
| codeA | input | 2 | Bank A ratio code |
| codeB | input | 2 | Bank B ratio code |
| codeC | input | 2 | Bank C ratio code |
| fbCode | input | 3 | Feedback lane ratio code |
| flipC23 | input | 1 | Invert bank C lanes 2 and 3 |
| laneEn | input | 12 | Per-lane enable, bit 4*bank+lane |
| clkA | output | 4 | Bank A clocks |
| clkB | output | 4 | Bank B clocks |
| clkC | output | 4 | Bank C clocks |
| clkFb | output | 1 | Feedback clock |

## Verification
The hardest case to reach is a code change that lands in the middle of an output period. It must land at a chosen phase, and the period in progress must also be observed, not skipped over. The bench handles this by recording every edge of one lane over a fixed window. It applies the new code at a known step inside that window and then rebuilds each complete period from the recorded rises and falls. Each of those periods is checked against the old and new ratios. The switch cases cover both a speed-up and a slow-down on one bank code, plus a fastMode flip in both directions.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int NBANK = 3;
  parameter int NOUT = 4;
  parameter int NCH = NBANK + 1;
  parameter int NEN = NBANK * NOUT;
  parameter int RATIO_W = 6;
  parameter int SYNC_STAGES = 2;
  parameter logic [NOUT-1:0] INV_LAST_MASK = {{(NOUT - NOUT/2){1'b1}}, {(NOUT/2){1'b0}}};

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic start;
    logic inv;
    logic [NEN-1:0] en;
    ratio_t [NCH-1:0] ratio;
  } ctrl_t;

  function automatic ratio_t bankRatio(input int bank, input logic [1:0] code, input logic fast);
    ratio_t base;
    case (code)
      2'd0: base = (bank == 2) ? ratio_t'(2) : ratio_t'(4);
      2'd1: base = (bank == 2) ? ratio_t'(4) : ratio_t'(6);
      2'd2: base = (bank == 2) ? ratio_t'(6) : ratio_t'(8);
      default: base = (bank == 0) ? ratio_t'(12) : ((bank == 1) ? ratio_t'(10) : ratio_t'(8));
    endcase
    return fast ? base : ratio_t'(base << 1);
  endfunction

  function automatic ratio_t fbRatio(input logic [2:0] code, input logic fast);
    ratio_t base;
    case (code[1:0])
      2'd0: base = ratio_t'(4);
      2'd1: base = ratio_t'(6);
      2'd2: base = ratio_t'(8);
      default: base = ratio_t'(10);
    endcase
    if (code[2]) base = ratio_t'(base << 1);
    if (!fast) base = ratio_t'(base << 1);
    return base;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic                  clk,
  input  logic                  resetN,
  input  logic                  fastMode,
  input  logic [NBANK-1:0][1:0] bankCode,
  input  logic [2:0]            fbCode,
  input  logic                  flipC23,
  input  logic [NEN-1:0]        laneEn,
  output ctrl_t                 ctrl
);
  localparam int SW = 1 + 2*NBANK + 3 + 1 + NEN;
  localparam int CW = $clog2(SYNC_STAGES + 2);

  logic [SW-1:0] rawIn;
  logic [SYNC_STAGES-1:0][SW-1:0] syncQ;
  logic [CW-1:0] settleCnt;

  logic sFast;
  logic [NBANK-1:0][1:0] sBank;
  logic [2:0] sFb;
  logic sInv;
  logic [NEN-1:0] sEn;

  assign rawIn = {fastMode, bankCode, fbCode, flipC23, laneEn};

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      syncQ <= '0;
      settleCnt <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      if (settleCnt != CW'(SYNC_STAGES + 1)) settleCnt <= settleCnt + CW'(1);
    end
  end

  assign {sFast, sBank, sFb, sInv, sEn} = syncQ[SYNC_STAGES-1];

  always_comb begin
    ctrl.start = (settleCnt == CW'(SYNC_STAGES));
    ctrl.inv = sInv;
    ctrl.en = sEn;
    for (int b = 0; b < NBANK; b++) ctrl.ratio[b] = bankRatio(b, sBank[b], sFast);
    ctrl.ratio[NBANK] = fbRatio(sFb, sFast);
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int LANES = 4,
  parameter logic [LANES-1:0] INV_MASK = '0
) (
  input  logic             clk,
  input  logic             resetN,
  input  logic             start,
  input  ratio_t           ratioNew,
  input  logic [LANES-1:0] enNew,
  input  logic             invNew,
  output logic [LANES-1:0] q
);
  logic live;
  ratio_t cnt, ratioCur, cntInc;
  logic [LANES-1:0] enCur, enNext, qNext;
  logic invCur, invNext, boundary, phaseNext, liveNext;

  always_comb begin
    cntInc = cnt + ratio_t'(1);
    boundary = start | (live & (cnt == ratioCur - ratio_t'(1)));
    phaseNext = boundary | (live & (cntInc < (ratioCur >> 1)));
    enNext = boundary ? enNew : enCur;
    invNext = boundary ? invNew : invCur;
    liveNext = live | start;
    for (int k = 0; k < LANES; k++)
      qNext[k] = liveNext & enNext[k] & (phaseNext ^ (invNext & INV_MASK[k]));
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      live <= 1'b0;
      cnt <= '0;
      ratioCur <= ratio_t'(2);
      enCur <= '0;
      invCur <= 1'b0;
      q <= '0;
    end else begin
      live <= liveNext;
      enCur <= enNext;
      invCur <= invNext;
      q <= qNext;
      if (boundary) begin
        cnt <= '0;
        ratioCur <= ratioNew;
      end else if (live) begin
        cnt <= cntInc;
      end
    end
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic                      clk,
  input  logic                      resetN,
  input  ctrl_t                     ctrl,
  output logic [NBANK-1:0][NOUT-1:0] qBank,
  output logic                      fbOut
);
  for (genvar b = 0; b < NBANK; b++) begin : gBank
    localparam logic [NOUT-1:0] MASK = (b == NBANK-1) ? INV_LAST_MASK : '0;
    clkdiv_chan #(.LANES(NOUT), .INV_MASK(MASK)) uChan (
      .clk(clk),
      .resetN(resetN),
      .start(ctrl.start),
      .ratioNew(ctrl.ratio[b]),
      .enNew(ctrl.en[b*NOUT +: NOUT]),
      .invNew(ctrl.inv),
      .q(qBank[b])
    );
  end

  clkdiv_chan #(.LANES(1), .INV_MASK(1'b0)) uFb (
    .clk(clk),
    .resetN(resetN),
    .start(ctrl.start),
    .ratioNew(ctrl.ratio[NBANK]),
    .enNew(1'b1),
    .invNew(1'b0),
    .q(fbOut)
  );
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic            clk,
  input  logic            resetN,
  input  logic            fastMode,
  input  logic [1:0]      codeA,
  input  logic [1:0]      codeB,
  input  logic [1:0]      codeC,
  input  logic [2:0]      fbCode,
  input  logic            flipC23,
  input  logic [NEN-1:0]  laneEn,
  output logic [NOUT-1:0] clkA,
  output logic [NOUT-1:0] clkB,
  output logic [NOUT-1:0] clkC,
  output logic            clkFb
);
  ctrl_t ctrlBus;
  logic [NBANK-1:0][NOUT-1:0] qBank;

  clkdiv_ctrl uCtrl (
    .clk(clk),
    .resetN(resetN),
    .fastMode(fastMode),
    .bankCode({codeC, codeB, codeA}),
    .fbCode(fbCode),
    .flipC23(flipC23),
    .laneEn(laneEn),
    .ctrl(ctrlBus)
  );

  clkdiv_datapath uData (
    .clk(clk),
    .resetN(resetN),
    .ctrl(ctrlBus),
    .qBank(qBank),
    .fbOut(clkFb)
  );

  assign clkA = qBank[0];
  assign clkB = qBank[1];
  assign clkC = qBank[2];
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
(
  input logic             clk,
  input logic             resetN,
  input logic [NOUT-1:0]  clkA,
  input logic [NOUT-1:0]  clkB,
  input logic [NOUT-1:0]  clkC,
  input logic             clkFb,
  input logic             ctrlStart,
  input ratio_t [NCH-1:0] ctrlRatio
);
  localparam int FB_HALF_MIN = int'(fbRatio(3'b000, 1'b1)) / 2;
  localparam int FB_HALF_MAX = int'(fbRatio(3'b111, 1'b0)) / 2;
  localparam int A_HALF_MIN = int'(bankRatio(0, 2'd0, 1'b1)) / 2;
  localparam int A_HALF_MAX = int'(bankRatio(0, 2'd3, 1'b0)) / 2;

  logic fbPrev, aPrev;
  logic [RATIO_W-1:0] fbRun, aRun;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      fbPrev <= 1'b0;
      fbRun <= '0;
      aPrev <= 1'b0;
      aRun <= '0;
    end else begin
      fbPrev <= clkFb;
      if (clkFb != fbPrev) fbRun <= RATIO_W'(1);
      else if (fbRun != '1) fbRun <= fbRun + RATIO_W'(1);
      aPrev <= clkA[0];
      if (!clkA[0]) aRun <= '0;
      else if (aRun != '1) aRun <= aRun + RATIO_W'(1);
    end
  end

  // R8: outputs quiet in reset
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !resetN |-> (clkA == '0 && clkB == '0 && clkC == '0 && !clkFb));

  // R9: start strobe is a single pulse
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!resetN)
    ctrlStart |=> !ctrlStart);

  // R9: feedback lane rises on the edge that consumes the start strobe
  assert_first_rise_R9: assert property (@(posedge clk) disable iff (!resetN)
    ctrlStart |=> clkFb);

  // R5: every ratio presented to the counters is even and nonzero
  for (genvar c = 0; c < NCH; c++) begin : gEven
    assert_even_ratio_R5: assert property (@(posedge clk) disable iff (!resetN)
      (ctrlRatio[c][0] == 1'b0) && (ctrlRatio[c] != '0));
  end

  // R6: feedback half periods stay inside the legal range (no runt, no stretch)
  assert_fb_run_R6: assert property (@(posedge clk) disable iff (!resetN)
    (clkFb != fbPrev) |-> (int'(fbRun) >= FB_HALF_MIN && int'(fbRun) <= FB_HALF_MAX));

  // R6: bank A high phases stay inside the legal range
  assert_a_high_R6: assert property (@(posedge clk) disable iff (!resetN)
    (aPrev && !clkA[0]) |-> (int'(aRun) >= A_HALF_MIN && int'(aRun) <= A_HALF_MAX));
endmodule

bind clkdiv_bank clkdiv_bank_chk chk (
  .clk(clk),
  .resetN(resetN),
  .clkA(clkA),
  .clkB(clkB),
  .clkC(clkC),
  .clkFb(clkFb),
  .ctrlStart(ctrlBus.start),
  .ctrlRatio(ctrlBus.ratio)
);

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
  logic clk = 1'b0;
  logic resetN = 1'b0;
  logic fastMode = 1'b1;
  logic [1:0] codeA = '0, codeB = '0, codeC = '0;
  logic [2:0] fbCode = '0;
  logic flipC23 = 1'b0;
  logic [11:0] laneEn = '1;
  logic [3:0] clkA, clkB, clkC;
  logic clkFb;
  logic [12:0] allQ, curQ, prevQ;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  clkdiv_bank uut (
    .clk(clk), .resetN(resetN), .fastMode(fastMode),
    .codeA(codeA), .codeB(codeB), .codeC(codeC), .fbCode(fbCode),
    .flipC23(flipC23), .laneEn(laneEn),
    .clkA(clkA), .clkB(clkB), .clkC(clkC), .clkFb(clkFb)
  );

  assign allQ = {clkFb, clkC, clkB, clkA};

  initial begin
    curQ = '0;
    prevQ = '0;
  end

  task automatic step();
    @(negedge clk);
    prevQ = curQ;
    curQ = allQ;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expRatio(input int ch, input int code, input bit fast, input bit [2:0] fb);
    int m;
    case (ch)
      0: m = (code == 3) ? 12 : 4 + 2*code;
      1: m = 4 + 2*code;
      2: m = 2 + 2*code;
      default: m = (4 + 2*int'(fb[1:0])) * (fb[2] ? 2 : 1);
    endcase
    return fast ? m : 2*m;
  endfunction

  task automatic syncRise(input int idx);
    step();
    while (!(prevQ[idx] == 1'b0 && curQ[idx] == 1'b1)) step();
  endtask

  task automatic measure(input int idx, output int hi, output int per);
    int lo;
    hi = 1;
    step();
    while (curQ[idx]) begin hi++; step(); end
    lo = 0;
    while (!curQ[idx]) begin lo++; step(); end
    per = hi + lo;
  endtask

  task automatic releaseAndAlign(input string tag);
    int n;
    resetN = 1'b1;
    n = 0;
    do begin step(); n++; end while (curQ == '0 && n < 20);
    check(n == 3, "R9", {tag, " edges to first rise"}, n, 3);
    check(curQ == 13'h1FFF, "R9", {tag, " all lanes rise together"}, int'(curQ), 13'h1FFF);
  endtask

  task automatic testResetState();
    repeat (4) step();
    check(curQ == '0, "R8", "outputs low during reset", int'(curQ), 0);
    releaseAndAlign("initial release");
  endtask

  task automatic testRatios();
    int hi, per, exp;
    string tag;
    for (int f = 1; f >= 0; f--) begin
      for (int code = 0; code < 4; code++) begin
        fastMode = f[0];
        codeA = code[1:0]; codeB = code[1:0]; codeC = code[1:0];
        fbCode = {code[1] ^ code[0], code[1:0]};
        repeat (100) step();
        for (int ch = 0; ch < 4; ch++) begin
          syncRise(ch * 4);
          measure(ch * 4, hi, per);
          exp = expRatio(ch, code, f[0], fbCode);
          if (f == 0) tag = "R3";
          else if (ch == 0) tag = "R1";
          else if (ch == 3) tag = "R4";
          else tag = "R2";
          check(per == exp, tag, $sformatf("period ch%0d code%0d fast%0d", ch, code, f), per, exp);
          check(2*hi == per, "R5", $sformatf("duty ch%0d code%0d fast%0d", ch, code, f), hi, per/2);
        end
      end
    end
  endtask

  // what: 0 = codeA, 1 = fastMode
  task automatic observeSwitch(input int idx, input int k, input int what, input int val,
                               input int oldP, input int newP);
    int lastRise = -1, lastFall = -1, per = 0, hi, lastPer = 0;
    bit seenNew = 0;
    for (int t = 0; t < 140; t++) begin
      if (t == k) begin
        if (what == 0) codeA = val[1:0];
        else fastMode = val[0];
      end
      step();
      if (!prevQ[idx] && curQ[idx]) begin
        if (lastRise >= 0 && lastFall > lastRise) begin
          per = t - lastRise;
          hi = lastFall - lastRise;
          check(per == oldP || per == newP, "R6", "period is old or new", per, newP);
          check(2*hi == per, "R6", "no runt high phase", hi, per/2);
          check(!(seenNew && per == oldP && oldP != newP), "R6", "old period after new", per, newP);
          if (per == newP) seenNew = 1;
          lastPer = per;
        end
        lastRise = t;
      end
      if (prevQ[idx] && !curQ[idx]) lastFall = t;
    end
    check(lastPer == newP, "R6", "settles on new period", lastPer, newP);
  endtask

  task automatic testGlitch();
    fastMode = 1'b1; codeA = 2'd0; codeB = 2'd3; codeC = 2'd1; fbCode = 3'd0;
    repeat (80) step();
    syncRise(0);
    observeSwitch(0, 1, 0, 3, 4, 12);
    syncRise(0);
    observeSwitch(0, 5, 0, 0, 12, 4);
    observeSwitch(8, 3, 1, 0, 4, 8);
    syncRise(4);
    observeSwitch(4, 7, 1, 1, 20, 10);
  endtask

  task automatic testFlip();
    int bad;
    fastMode = 1'b1; codeC = 2'd2;
    flipC23 = 1'b1;
    repeat (60) step();
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (curQ[10] != ~curQ[8] || curQ[11] != ~curQ[8] || curQ[9] != curQ[8]) bad++;
    end
    check(bad == 0, "R7", "lanes C2/C3 inverted, C1 plain", bad, 0);
    flipC23 = 1'b0;
    repeat (60) step();
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (curQ[10] != curQ[8] || curQ[11] != curQ[8]) bad++;
    end
    check(bad == 0, "R7", "no inversion when flip low", bad, 0);
  endtask

  task automatic testEnable();
    int bad, highs, n;
    fastMode = 1'b1; codeA = 2'd2;
    laneEn[1] = 1'b0;
    repeat (60) step();
    bad = 0; highs = 0;
    for (int i = 0; i < 50; i++) begin
      step();
      if (curQ[1]) bad++;
      if (curQ[0]) highs++;
    end
    check(bad == 0, "R10", "disabled lane held low", bad, 0);
    check(highs > 0, "R10", "neighbour lane still running", highs, 25);
    syncRise(0);
    step();
    laneEn[1] = 1'b1;
    n = 0;
    do begin step(); n++; end while (!(prevQ[1] == 1'b0 && curQ[1] == 1'b1) && n < 100);
    check(prevQ[0] == 1'b0 && curQ[0] == 1'b1, "R10", "re-enabled lane resumes on period start",
          int'(curQ[0]), 1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (curQ[1] != curQ[0]) bad++;
    end
    check(bad == 0, "R10", "re-enabled lane tracks bank", bad, 0);
  endtask

  task automatic testResetMidRun();
    repeat (7) step();
    resetN = 1'b0;
    step();
    check(curQ == '0, "R8", "outputs drop with reset", int'(curQ), 0);
    repeat (5) step();
    check(curQ == '0, "R8", "outputs stay low in reset", int'(curQ), 0);
    fastMode = 1'b0; codeA = 2'd3; codeB = 2'd1; codeC = 2'd2; fbCode = 3'd5;
    releaseAndAlign("second release");
  endtask

  initial begin
    testResetState();
    testRatios();
    testGlitch();
    testFlip();
    testEnable();
    testResetMidRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule